// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines two guesses and picks between them with a chooser that learns over time. The first guess is a per-branch (local) guess. The instruction word address is folded into an index into a table of per-branch outcome histories, and that history then selects a 3-bit saturating counter. The second guess is a path (global) guess: a 2-bit counter selected by a shift register that holds the most recent branch directions. A third table of 2-bit counters, indexed by that same global history, decides which of the two guesses is used.

The front end calls the predict port once per conditional branch. The block returns the final direction, both component guesses and the history value it used. The history register then shifts in the guessed direction on the next clock, without waiting for the branch to resolve. When a branch resolves, the back end presents all of those values again on the update port so the tables can be trained. When the guess was wrong, the back end also uses the restore port to rebuild the history from the snapshot and the real outcome.

Top module: `tourney_predictor`

## Requirements
- R1: After reset, the global history is zero. Every local history is zero. Local counters hold 3, global counters hold 1 and choice counters hold 1, so every prediction is not-taken and the chooser selects the local guess.
- R2: The local history table index is an XOR fold of the word address: bit i of the address is XORed into index bit (i mod LH_IDX). On a resolved update, the entry for updPc shifts the outcome into its LSB.
- R3: predLocal is the MSB of the 3-bit local counter selected by the local history of predPc. On update, that counter (selected by the pre-shift local history of updPc) counts up on taken and down on not-taken, and saturates at 7 and at 0.
- R4: predGlobal is the MSB of the 2-bit global counter selected by the current global history. On update, the counter at updHist trains toward the outcome and saturates at 0 and 3.
- R5: predTaken equals predGlobal when the MSB of the choice counter at the current history is 1, and equals predLocal otherwise.
- R6: The choice counter at updHist changes only when updLocal differs from updGlobal. It counts up when the global guess matched the outcome and down when the local guess did, saturating at 0 and 3.
- R7: predHist gives the global history used for the prediction. One cycle after a predict without a restore, the history equals the old value shifted left with predTaken in the LSB.
- R8: One cycle after fixValid, the history equals fixHist shifted left by one with fixTaken in the LSB. This wins over a predict in the same cycle.
- R9: Training of the global and choice counters uses the snapshot updHist, not the live history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predValid | input | 1 | A prediction is consumed this cycle |
| predPc | input | PC_W | Word address of the branch to predict |
| predTaken | output | 1 | Final direction |
| predLocal | output | 1 | Local component guess |
| predGlobal | output | 1 | Global component guess |
| predHist | output | GH_W | Global history used for this prediction |
| updValid | input | 1 | A resolved branch trains the tables |
| updPc | input | PC_W | Word address of the resolved branch |
| updTaken | input | 1 | Resolved direction |
| updLocal | input | 1 | Local guess given at prediction time |
| updGlobal | input | 1 | Global guess given at prediction time |
| updHist | input | GH_W | History snapshot given at prediction time |
| fixValid | input | 1 | Rebuild the global history after a wrong guess |
| fixTaken | input | 1 | Real direction of the wrongly guessed branch |
| fixHist | input | GH_W | History snapshot of that branch |

## Verification
Several behaviours are checked by assertions on every cycle:
- the history shift after a predict, the rebuild after a restore, and the history holding when neither occurs;
- the final direction matching both components whenever they agree;
- the chooser being left alone when the components agree;
- the counter strobes never asking for increment and decrement at once.

Only the bench scenarios can show that the tables learn. These scenarios include a loop branch with periodic exits, a pair of correlated branches, counter saturation, a restore that collides with a predict, and a long mixed stream. In each of them, every returned guess is compared against an independent model of the tables.

// File: rtl/tourney_pkg.sv
`timescale 1ns/1ps
package tourney_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic lhShift;   // shift resolved outcome into local history
    logic lhBit;
    logic lcInc;     // local counter up
    logic lcDec;     // local counter down
    logic gcInc;     // global counter up
    logic gcDec;     // global counter down
    logic ccInc;     // choice counter toward global
    logic ccDec;     // choice counter toward local
    logic ghShift;   // speculative history shift
    logic ghLoad;    // history rebuild from snapshot
    logic ghBit;     // bit entering the history
  } strobe_t;

endpackage

// File: rtl/tourney_ctrl.sv
`timescale 1ns/1ps
module tourney_ctrl
  import tourney_pkg::*;
#(
  parameter int LC_W = 3,
  parameter int GC_W = 2,
  parameter int CC_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            predValid,
  input  logic [LC_W-1:0] lcPred,
  input  logic [GC_W-1:0] gcPred,
  input  logic [CC_W-1:0] ccPred,
  input  logic            updValid,
  input  logic            updTaken,
  input  logic            updLocal,
  input  logic            updGlobal,
  input  logic [LC_W-1:0] lcUpd,
  input  logic [GC_W-1:0] gcUpd,
  input  logic [CC_W-1:0] ccUpd,
  input  logic            fixValid,
  input  logic            fixTaken,
  output logic            predTaken,
  output logic            predLocal,
  output logic            predGlobal,
  output strobe_t         st
);

  logic disagree;
  logic globalRight;
  logic localRight;

  assign predLocal  = lcPred[LC_W-1];
  assign predGlobal = gcPred[GC_W-1];
  assign predTaken  = ccPred[CC_W-1] ? predGlobal : predLocal;

  assign disagree    = updLocal != updGlobal;
  assign globalRight = updGlobal == updTaken;
  assign localRight  = updLocal == updTaken;

  always_comb begin
    st         = '0;
    st.lhShift = updValid;
    st.lhBit   = updTaken;
    st.lcInc   = updValid &&  updTaken && (lcUpd != '1);
    st.lcDec   = updValid && !updTaken && (lcUpd != '0);
    st.gcInc   = updValid &&  updTaken && (gcUpd != '1);
    st.gcDec   = updValid && !updTaken && (gcUpd != '0);
    st.ccInc   = updValid && disagree && globalRight && (ccUpd != '1);
    st.ccDec   = updValid && disagree && localRight  && (ccUpd != '0);
    st.ghLoad  = fixValid;
    st.ghShift = predValid && !fixValid;
    st.ghBit   = fixValid ? fixTaken : predTaken;
  end

  // R3 R4 R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(st.lcInc && st.lcDec) && !(st.gcInc && st.gcDec) && !(st.ccInc && st.ccDec));

  // R6
  choice_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && (updLocal == updGlobal)) |-> (!st.ccInc && !st.ccDec));

endmodule

// File: rtl/tourney_dpath.sv
`timescale 1ns/1ps
module tourney_dpath
  import tourney_pkg::*;
#(
  parameter int PC_W   = 30,
  parameter int LH_IDX = 10,
  parameter int LH_W   = 10,
  parameter int LC_W   = 3,
  parameter int GH_W   = 12,
  parameter int GC_W   = 2,
  parameter int CC_W   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  input  logic [PC_W-1:0] updPc,
  input  logic [GH_W-1:0] updHist,
  input  logic [GH_W-1:0] fixHist,
  input  strobe_t         st,
  output logic [LC_W-1:0] lcPred,
  output logic [GC_W-1:0] gcPred,
  output logic [CC_W-1:0] ccPred,
  output logic [LC_W-1:0] lcUpd,
  output logic [GC_W-1:0] gcUpd,
  output logic [CC_W-1:0] ccUpd,
  output logic [GH_W-1:0] ghr
);

  localparam int LH_N = 1 << LH_IDX;
  localparam int LC_N = 1 << LH_W;
  localparam int GC_N = 1 << GH_W;
  localparam logic [LC_W-1:0] LC_INIT = LC_W'((1 << (LC_W-1)) - 1);
  localparam logic [GC_W-1:0] GC_INIT = GC_W'((1 << (GC_W-1)) - 1);
  localparam logic [CC_W-1:0] CC_INIT = CC_W'((1 << (CC_W-1)) - 1);

  logic [LH_W-1:0] lhTab [LH_N];
  logic [LC_W-1:0] lcTab [LC_N];
  logic [GC_W-1:0] gcTab [GC_N];
  logic [CC_W-1:0] ccTab [GC_N];

  logic [LH_IDX-1:0] idxPred;
  logic [LH_IDX-1:0] idxUpd;
  logic [LH_W-1:0]   lhPred;
  logic [LH_W-1:0]   lhUpd;

  function automatic logic [LH_IDX-1:0] foldPc(input logic [PC_W-1:0] pc);
    logic [LH_IDX-1:0] r;
    r = '0;
    for (int i = 0; i < PC_W; i++) r[i % LH_IDX] = r[i % LH_IDX] ^ pc[i];
    return r;
  endfunction

  assign idxPred = foldPc(predPc);
  assign idxUpd  = foldPc(updPc);
  assign lhPred  = lhTab[idxPred];
  assign lhUpd   = lhTab[idxUpd];
  assign lcPred  = lcTab[lhPred];
  assign gcPred  = gcTab[ghr];
  assign ccPred  = ccTab[ghr];
  assign lcUpd   = lcTab[lhUpd];
  assign gcUpd   = gcTab[updHist];
  assign ccUpd   = ccTab[updHist];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LH_N; i++) lhTab[i] <= '0;
      for (int i = 0; i < LC_N; i++) lcTab[i] <= LC_INIT;
    end else begin
      if (st.lcInc) lcTab[lhUpd] <= lcUpd + LC_W'(1);
      else if (st.lcDec) lcTab[lhUpd] <= lcUpd - LC_W'(1);
      if (st.lhShift) lhTab[idxUpd] <= {lhUpd[LH_W-2:0], st.lhBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GC_N; i++) begin
        gcTab[i] <= GC_INIT;
        ccTab[i] <= CC_INIT;
      end
    end else begin
      if (st.gcInc) gcTab[updHist] <= gcUpd + GC_W'(1);
      else if (st.gcDec) gcTab[updHist] <= gcUpd - GC_W'(1);
      if (st.ccInc) ccTab[updHist] <= ccUpd + CC_W'(1);
      else if (st.ccDec) ccTab[updHist] <= ccUpd - CC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ghr <= '0;
    else if (st.ghLoad) ghr <= {fixHist[GH_W-2:0], st.ghBit};
    else if (st.ghShift) ghr <= {ghr[GH_W-2:0], st.ghBit};
  end

endmodule

// File: rtl/tourney_predictor.sv
`timescale 1ns/1ps
module tourney_predictor
  import tourney_pkg::*;
#(
  parameter int PC_W   = 30,
  parameter int LH_IDX = 10,
  parameter int LH_W   = 10,
  parameter int LC_W   = 3,
  parameter int GH_W   = 12,
  parameter int GC_W   = 2,
  parameter int CC_W   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            predValid,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  output logic            predLocal,
  output logic            predGlobal,
  output logic [GH_W-1:0] predHist,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic            updLocal,
  input  logic            updGlobal,
  input  logic [GH_W-1:0] updHist,
  input  logic            fixValid,
  input  logic            fixTaken,
  input  logic [GH_W-1:0] fixHist
);

  strobe_t         st;
  logic [LC_W-1:0] lcPred, lcUpd;
  logic [GC_W-1:0] gcPred, gcUpd;
  logic [CC_W-1:0] ccPred, ccUpd;
  logic [GH_W-1:0] ghr;

  assign predHist = ghr;

  tourney_ctrl #(.LC_W(LC_W), .GC_W(GC_W), .CC_W(CC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .predValid(predValid),
    .lcPred(lcPred), .gcPred(gcPred), .ccPred(ccPred),
    .updValid(updValid), .updTaken(updTaken), .updLocal(updLocal), .updGlobal(updGlobal),
    .lcUpd(lcUpd), .gcUpd(gcUpd), .ccUpd(ccUpd),
    .fixValid(fixValid), .fixTaken(fixTaken),
    .predTaken(predTaken), .predLocal(predLocal), .predGlobal(predGlobal), .st(st)
  );

  tourney_dpath #(.PC_W(PC_W), .LH_IDX(LH_IDX), .LH_W(LH_W), .LC_W(LC_W),
                  .GH_W(GH_W), .GC_W(GC_W), .CC_W(CC_W)) dpath_i (
    .clk(clk), .rstN(rstN), .predPc(predPc), .updPc(updPc), .updHist(updHist),
    .fixHist(fixHist), .st(st),
    .lcPred(lcPred), .gcPred(gcPred), .ccPred(ccPred),
    .lcUpd(lcUpd), .gcUpd(gcUpd), .ccUpd(ccUpd), .ghr(ghr)
  );

  // R7
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && !fixValid) |=> predHist == {$past(predHist[GH_W-2:0]), $past(predTaken)});

  // R8
  hist_fix_chk: assert property (@(posedge clk) disable iff (!rstN)
    fixValid |=> predHist == {$past(fixHist[GH_W-2:0]), $past(fixTaken)});

  // R7 R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!predValid && !fixValid) |=> $stable(predHist));

  // R5
  agree_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (predLocal == predGlobal) |-> (predTaken == predLocal));

endmodule

// File: tb/tourney_predictor_tb.sv
`timescale 1ns/1ps
module tourney_predictor_tb_top;

  localparam int PW = 30;
  localparam int LI = 10;
  localparam int LW = 10;
  localparam int GW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic predValid = 1'b0, updValid = 1'b0, fixValid = 1'b0;
  logic [PW-1:0] predPc = '0, updPc = '0;
  logic updTaken = 1'b0, updLocal = 1'b0, updGlobal = 1'b0, fixTaken = 1'b0;
  logic [GW-1:0] updHist = '0, fixHist = '0;
  logic predTaken, predLocal, predGlobal;
  logic [GW-1:0] predHist;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tourney_predictor dut_i (
    .clk(clk), .rstN(rstN), .predValid(predValid), .predPc(predPc),
    .predTaken(predTaken), .predLocal(predLocal), .predGlobal(predGlobal), .predHist(predHist),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updLocal(updLocal),
    .updGlobal(updGlobal), .updHist(updHist),
    .fixValid(fixValid), .fixTaken(fixTaken), .fixHist(fixHist)
  );

  // Reference tables built from the requirements
  logic [LW-1:0] mLh [1<<LI];
  logic [2:0]    mLc [1<<LW];
  logic [1:0]    mGc [1<<GW];
  logic [1:0]    mCc [1<<GW];
  logic [GW-1:0] mGhr;

  typedef struct {
    logic t;
    logic l;
    logic g;
    logic [GW-1:0] h;
  } exp_t;
  exp_t q[$];

  function automatic logic [LI-1:0] mFold(input logic [PW-1:0] pc);
    logic [LI-1:0] r;
    r = '0;
    for (int i = 0; i < PW; i++) r[i % LI] = r[i % LI] ^ pc[i];
    return r;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < (1<<LI); i++) mLh[i] = '0;
    for (int i = 0; i < (1<<LW); i++) mLc[i] = 3'd3;
    for (int i = 0; i < (1<<GW); i++) begin mGc[i] = 2'd1; mCc[i] = 2'd1; end
    mGhr = '0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Model predict from pre-clock state
  function automatic exp_t mPredict(input logic [PW-1:0] pc);
    exp_t e;
    e.l = mLc[mLh[mFold(pc)]][2];
    e.g = mGc[mGhr][1];
    e.t = mCc[mGhr][1] ? e.g : e.l;
    e.h = mGhr;
    return e;
  endfunction

  task automatic doPredict(input logic [PW-1:0] pc, output exp_t e);
    @(negedge clk);
    updValid = 1'b0; fixValid = 1'b0;
    predValid = 1'b1; predPc = pc;
    e = mPredict(pc);
    q.push_back(e);
    mGhr = {mGhr[GW-2:0], e.t};
  endtask

  task automatic doUpdate(input logic [PW-1:0] pc, input logic tk, input exp_t e);
    logic [LI-1:0] ix;
    logic [LW-1:0] lh;
    @(negedge clk);
    predValid = 1'b0; fixValid = 1'b0;
    updValid = 1'b1; updPc = pc; updTaken = tk;
    updLocal = e.l; updGlobal = e.g; updHist = e.h;
    ix = mFold(pc);
    lh = mLh[ix];
    if (tk && mLc[lh] != 3'd7) mLc[lh] = mLc[lh] + 3'd1;
    if (!tk && mLc[lh] != 3'd0) mLc[lh] = mLc[lh] - 3'd1;
    if (tk && mGc[e.h] != 2'd3) mGc[e.h] = mGc[e.h] + 2'd1;
    if (!tk && mGc[e.h] != 2'd0) mGc[e.h] = mGc[e.h] - 2'd1;
    if (e.l != e.g) begin
      if (e.g == tk && mCc[e.h] != 2'd3) mCc[e.h] = mCc[e.h] + 2'd1;
      if (e.l == tk && mCc[e.h] != 2'd0) mCc[e.h] = mCc[e.h] - 2'd1;
    end
    mLh[ix] = {lh[LW-2:0], tk};
  endtask

  task automatic doFix(input logic [GW-1:0] h, input logic tk);
    @(negedge clk);
    predValid = 1'b0; updValid = 1'b0;
    fixValid = 1'b1; fixHist = h; fixTaken = tk;
    mGhr = {h[GW-2:0], tk};
  endtask

  task automatic idle();
    @(negedge clk);
    predValid = 1'b0; updValid = 1'b0; fixValid = 1'b0;
  endtask

  task automatic branch(input logic [PW-1:0] pc, input logic tk);
    exp_t e;
    doPredict(pc, e);
    if (e.t != tk) doFix(e.h, tk);
    doUpdate(pc, tk, e);
  endtask

  // Monitor: pops the expected item for every consumed prediction
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (predValid && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check("R7 R8 history", 32'(predHist), 32'(e.h));
        check("R2 R3 local", 32'(predLocal), 32'(e.l));
        check("R4 R9 global", 32'(predGlobal), 32'(e.g));
        check("R5 R6 final", 32'(predTaken), 32'(e.t));
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    exp_t e;
    exp_t e2;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state seen at the ports
    check("R1 history", 32'(predHist), 32'h0);
    check("R1 taken", 32'(predTaken), 32'h0);
    check("R1 local", 32'(predLocal), 32'h0);
    check("R1 global", 32'(predGlobal), 32'h0);

    // Loop branch, exit every fifth pass (R2 R3)
    for (int i = 0; i < 60; i++) branch(30'h40, (i % 5) != 4);

    // Saturation of local counter (R3): long taken run, then two exits
    for (int i = 0; i < 30; i++) branch(30'h1c0, 1'b1);
    branch(30'h1c0, 1'b0);
    branch(30'h1c0, 1'b0);
    for (int i = 0; i < 12; i++) branch(30'h1c0, 1'b0);

    // Correlated pair: second branch repeats the first (R4 R6 R9)
    lfsr = 16'hace1;
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      branch(30'h80, lfsr[0]);
      branch(30'h81, lfsr[0]);
    end

    // R8: restore collides with a predict in the same cycle
    doPredict(30'h99, e);
    @(negedge clk);
    updValid = 1'b0;
    fixValid = 1'b1; fixHist = 12'hA5C; fixTaken = 1'b1;
    predValid = 1'b1; predPc = 30'h99;
    e2 = mPredict(30'h99);
    q.push_back(e2);
    mGhr = {12'hA5C, 1'b1} & 12'hFFF;
    mGhr = {12'hA5C << 1} | 12'h001;
    idle();
    #1;
    check("R8 restore over predict", 32'(predHist), 32'h4B9);
    idle();
    #1;
    check("R7 history hold", 32'(predHist), 32'h4B9);

    // Mixed stream across eight branches (all requirements)
    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      k = lfsr[3:1];
      branch(30'h200 + 30'(k) * 30'h11, (k < 3'd4) ? (lfsr[0] | lfsr[5]) : (k[0] ^ lfsr[7]));
    end

    idle();
    idle();
    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL R7 queue actual=%0d expected=0", q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule